// File: doc/BRIEF.md
# Reset supervisor with power-on delay, brown-out hold and watchdog

This block produces one active-low reset request for a host processor. Three sources can pull it low. The first is the chip-level power-up reset, which is followed by a fixed settling delay. The second is a flag from an external low-supply comparator. The third is a watchdog timer that the host has to service. All timing is counted in pulses of a single-cycle enable (`tick_en`), which is derived from a 32.768 kHz timebase. The parameter `TICK_HZ` sets how many ticks make one second.

The hold delay is one quarter of a second, which is `TICK_HZ/4` ticks. The same hold delay is used after power-up, after the low-supply flag clears and after a watchdog expiry. The host picks the watchdog period with a 2-bit field: one of three lengths, or off. A kick strobe restarts the watchdog count, and so does any change of the select field. While the reset request is active, the watchdog count is held at zero.

Top module: `sup_reset_ctrl`

## Requirements
- R1: `rst_req_n` is active low. While `rst_n` is low it reads 0.
- R2: After `rst_n` rises, `rst_req_n` stays 0 for exactly `TICK_HZ/4` tick pulses and reads 1 after the last of them.
- R3: `low_volt` high drives `rst_req_n` to 0 from the next clock edge and holds it there while the flag stays high. Once the flag is low, release follows after `TICK_HZ/4` further ticks.
- R4: `wd_sel` sets the watchdog period in ticks: 2'b00 = 7*TICK_HZ/4, 2'b01 = 3*TICK_HZ/4, 2'b10 = TICK_HZ/4. If the period elapses with no restart, `rst_req_n` falls on the edge of the period-th tick.
- R5: A watchdog expiry holds `rst_req_n` at 0 for `TICK_HZ/4` ticks and then releases it.
- R6: `wd_sel` = 2'b11 disables the watchdog, so `rst_req_n` never falls from that source.
- R7: Both the hold timer and the watchdog advance only on cycles where `tick_en` is high.
- R8: A `wd_kick` pulse restarts the watchdog count from zero. A kick that arrives on the cycle that would expire wins, and no reset follows.
- R9: Any change of `wd_sel` restarts the watchdog count from zero.
- R10: The watchdog count is held at zero while `rst_req_n` is 0. A full period must therefore elapse after release before the next expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| tick_en | input | 1 | One-cycle enable per timebase tick |
| low_volt | input | 1 | Low-supply comparator flag, active high |
| wd_kick | input | 1 | Watchdog service strobe |
| wd_sel | input | 2 | Watchdog period select (00 longest, 01 middle, 10 shortest, 11 off) |
| rst_req_n | output | 1 | Reset request, active low |

## Verification
The embedded assertions check properties that can be judged cycle by cycle:
- a trigger always reaches the hold state one edge later;
- a release happens only on a tick;
- a kick, a select change or an active reset leaves the watchdog count at zero;
- the disabled setting never produces an expiry;
- the counters stay within their bounds.

Exact durations can only be shown by the bench's directed scenarios. These are the hold length after each source, the expiry edge for each of the three periods, the full period after a release, and the outcome when a kick coincides with the expiry edge.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;

  // Reset hold length in ticks: one quarter second.
  function automatic int unsigned hold_ticks(input int unsigned hz);
    return hz / 4;
  endfunction

  // Watchdog period in ticks for a select code; zero when disabled.
  function automatic int unsigned wd_period(input logic [1:0] sel, input int unsigned hz);
    case (sel)
      WD_LONG:  return (hz * 7) / 4;
      WD_MID:   return (hz * 3) / 4;
      WD_SHORT: return hz / 4;
      default:  return 0;
    endcase
  endfunction

  // Longest period, used to size the counters.
  function automatic int unsigned wd_max(input int unsigned hz);
    return (hz * 7) / 4;
  endfunction

endpackage

// File: rtl/sup_hold_timer.sv
module sup_hold_timer #(
  parameter int unsigned HOLD = 8192,
  parameter int unsigned CW   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic trigger,
  output logic hold_active
);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt;
  logic          hold_done;

  assign hold_done = hold_active & tick_en & ~trigger & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_active <= 1'b1;
      cnt         <= '0;
    end else if (trigger) begin
      hold_active <= 1'b1;
      cnt         <= '0;
    end else if (hold_done) begin
      hold_active <= 1'b0;
      cnt         <= '0;
    end else if (hold_active && tick_en) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3 / R5: any trigger is in the hold state after the next edge
  p_trigger_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> hold_active);

  // R7: release happens only on a tick
  p_release_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_active) |-> $past(tick_en));

  // R2: hold count never passes its last value
  p_hold_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog #(
  parameter int unsigned TICK_HZ = 32768,
  parameter int unsigned CW      = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       kick,
  input  logic [1:0] sel,
  input  logic       in_reset,
  output logic       expire
);
  import sup_pkg::*;

  localparam logic [CW-1:0] CNT_MAX = CW'(wd_max(TICK_HZ));

  logic [1:0]    sel_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          sel_moved;
  logic          restart;

  always_comb limit = CW'(wd_period(sel, TICK_HZ) - 1);

  assign sel_moved = (sel != sel_q);
  assign restart   = kick | sel_moved | in_reset | (sel == WD_OFF);
  assign expire    = tick_en & ~restart & (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= WD_LONG;
      cnt   <= '0;
    end else begin
      sel_q <= sel;
      if (restart || expire) cnt <= '0;
      else if (tick_en)      cnt <= cnt + 1'b1;
    end
  end

  // R8: a kick leaves the count at zero
  p_kick_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt == '0));

  // R9: a changed select leaves the count at zero
  p_sel_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != $past(sel)) |=> (cnt == '0));

  // R10: count is held cleared while reset is requested
  p_clear_in_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_reset |=> (cnt == '0));

  // R6: the off setting never expires
  p_off_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == WD_OFF) |-> !expire);

  // R4: count stays below the longest period
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_MAX);

endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl #(
  parameter int unsigned TICK_HZ = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       low_volt,
  input  logic       wd_kick,
  input  logic [1:0] wd_sel,
  output logic       rst_req_n
);
  import sup_pkg::*;

  localparam int unsigned HOLD = hold_ticks(TICK_HZ);
  localparam int unsigned CW   = $clog2(wd_max(TICK_HZ) + 1);

  logic wd_expire;
  logic hold_trigger;
  logic hold_active;

  assign hold_trigger = low_volt | wd_expire;

  sup_hold_timer #(.HOLD(HOLD), .CW(CW)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .trigger    (hold_trigger),
    .hold_active(hold_active)
  );

  sup_watchdog #(.TICK_HZ(TICK_HZ), .CW(CW)) u_wd (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .kick    (wd_kick),
    .sel     (wd_sel),
    .in_reset(hold_active),
    .expire  (wd_expire)
  );

  assign rst_req_n = ~hold_active;

  // R3: a low supply shows at the output one edge later
  p_low_volt_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    low_volt |=> !rst_req_n);

  // R5: an expiry shows at the output one edge later
  p_expire_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> !rst_req_n);

endmodule

// File: tb/sim_sup_reset_ctrl.sv
module sim_sup_reset_ctrl;
  localparam int HZ   = 64;
  localparam int HOLD = 16;    // quarter second at HZ
  localparam int P00  = 112;   // 1.75 s
  localparam int P01  = 48;    // 0.75 s
  localparam int P10  = 16;    // 0.25 s

  logic clk = 1'b0;
  logic rst_n, tick_en, low_volt, wd_kick;
  logic [1:0] wd_sel;
  logic rst_req_n;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  sup_reset_ctrl #(.TICK_HZ(HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .low_volt(low_volt),
    .wd_kick(wd_kick), .wd_sel(wd_sel), .rst_req_n(rst_req_n)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic exp);
    checks++;
    if (rst_req_n !== exp) begin
      fails++;
      $display("FAIL %s: rst_req_n=%b expected %b at %0t", req, rst_req_n, exp, $time);
    end
  endtask

  task automatic recover();
    step(HOLD);
    wd_sel = 2'b11;
    step(2);
  endtask

  task automatic t_power_on();
    step(3);
    chk("R1", 1'b0);
    rst_n = 1'b1;
    step(HOLD - 1); chk("R2", 1'b0);
    step(1);        chk("R2", 1'b1);
  endtask

  task automatic t_low_voltage();
    low_volt = 1'b1;
    step(1);  chk("R3", 1'b0);
    step(30); chk("R3", 1'b0);
    low_volt = 1'b0;
    step(HOLD - 1); chk("R3", 1'b0);
    step(1);        chk("R3", 1'b1);
  endtask

  task automatic t_tick_gate();
    low_volt = 1'b1; step(2); low_volt = 1'b0;
    tick_en = 1'b0;
    step(3 * HOLD); chk("R7", 1'b0);
    tick_en = 1'b1;
    step(HOLD - 1); chk("R7", 1'b0);
    step(1);        chk("R7", 1'b1);
    wd_sel = 2'b10; tick_en = 1'b0;
    step(1);
    step(50); chk("R7", 1'b1);
    tick_en = 1'b1;
    step(P10 - 1); chk("R7", 1'b1);
    step(1);       chk("R7", 1'b0);
    recover();
  endtask

  task automatic t_period(input logic [1:0] s, input int p);
    wd_sel = s;
    step(1);
    step(p - 1);    chk("R4", 1'b1);
    step(1);        chk("R4", 1'b0);
    step(HOLD - 1); chk("R5", 1'b0);
    step(1);        chk("R5", 1'b1);
    step(p - 1);    chk("R10", 1'b1);
    step(1);        chk("R10", 1'b0);
    recover();
  endtask

  task automatic t_kick();
    wd_sel = 2'b10;
    step(1);
    for (int i = 0; i < 6; i++) begin
      step(10);
      wd_kick = 1'b1; step(1); wd_kick = 1'b0;
      chk("R8", 1'b1);
    end
    step(P10 - 1); chk("R8", 1'b1);
    step(1);       chk("R8", 1'b0);
    recover();
    wd_sel = 2'b10;
    step(1);
    step(P10 - 1);
    wd_kick = 1'b1; step(1); wd_kick = 1'b0;
    chk("R8", 1'b1);
    step(P10 - 1); chk("R8", 1'b1);
    step(1);       chk("R8", 1'b0);
    recover();
  endtask

  task automatic t_sel_change();
    wd_sel = 2'b01;
    step(1);
    step(40);
    wd_sel = 2'b10;
    step(1);
    step(P10 - 1); chk("R9", 1'b1);
    step(1);       chk("R9", 1'b0);
    recover();
  endtask

  task automatic t_disabled();
    wd_sel = 2'b11;
    step(3 * P00 + 10);
    chk("R6", 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b1; low_volt = 1'b0; wd_kick = 1'b0; wd_sel = 2'b11;
    t_power_on();
    t_low_voltage();
    t_tick_gate();
    t_period(2'b00, P00);
    t_period(2'b01, P01);
    t_period(2'b10, P10);
    t_kick();
    t_sel_change();
    t_disabled();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule